// File: doc/BRIEF.md
# At-Speed Test Clock Controller

This block produces the single clock that drives scan flip-flops in a design under at-speed test. It receives a slow clock from the tester, a fast functional clock from an on-chip PLL, a scan-enable input and a static test-mode strap. It returns one gated clock. While the chain shifts, the gated clock follows the slow tester clock. When scan enable drops for capture, the slow path is blocked. A burst of exactly two back-to-back fast pulses is then released: the first launches a transition and the second captures the response. After that burst the clock stays low until scan enable is raised again.

Both paths are opened and closed through latch-based clock gates, and the two gated clocks are ORed together. No edge is ever cut short, and the two sources are never enabled at the same time. The falling edge of scan enable reaches the fast domain through a two-flop synchroniser and an edge detector, which load a short shift register. The low bit of that register is the fast gate's enable. With the test-mode strap low, the fast clock passes straight to the output and scan enable is ignored.

Assumptions: test mode changes only while reset is held, and the tester changes scan enable only while the slow clock is low.

Top module: `occ_clock_ctrl`

## Requirements
- R1: With test_mode low (and reset released), test_clk_o reproduces every fast_clk pulse. Any activity on scan_en leaves it unchanged.
- R2: With test_mode high and scan_en high, test_clk_o reproduces every slow_clk pulse at full width, including the first slow pulse after scan_en rises.
- R3: Once scan_en falls during a slow_clk low phase, no later slow_clk pulse reaches test_clk_o while scan_en stays low.
- R4: Each falling edge of scan_en in test mode yields exactly two rising edges on test_clk_o. These two edges are exactly one fast_clk period apart, and each pulse is one fast_clk high phase wide.
- R5: The first burst pulse coincides with the fourth rising edge of fast_clk after scan_en falls: two synchroniser stages, one edge-detect stage, and one load stage.
- R6: After the two pulses, test_clk_o stays low for however long scan_en remains low. A new burst is armed only after scan_en rises and falls again.
- R7: No high or low phase of test_clk_o is shorter than half a fast_clk period, including at each switch between sources. The slow and fast gates are never open together.
- R8: rst_n is synchronous and active low, and clears the burst logic. In test mode with scan_en low, neither reset nor its release produces any pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast functional clock from the PLL |
| slow_clk | input | 1 | Slow clock supplied by the tester |
| rst_n | input | 1 | Synchronous active-low reset, fast domain |
| test_mode | input | 1 | Static strap: 1 selects test clocking, 0 functional pass-through |
| scan_en | input | 1 | 1 = shift, 0 = capture; changes while slow_clk is low |
| test_clk_o | output | 1 | Gated clock for the scan flip-flops |

## Verification
The capture burst is tried with scan enable falling at ten different offsets inside the slow clock's low phase. This spreads the fall across the whole fast period, so a synchroniser or load stage that is one cycle short or long shows up as a wrong launch time. Holding capture far longer than the burst separates a correct two-pulse burst from a free-running or re-triggering one. Returning to shift after each burst exposes runt pulses at the switchover. Toggling scan enable in functional mode, and holding it low across reset release in test mode, separates a correct ignore from a spurious burst.

// File: rtl/occ_pkg.sv
// Package: shared constants for the at-speed test clock controller.
// Assumes: the burst length is fixed by the launch/capture scheme.
package occ_pkg;
    // Number of fast pulses released in one capture window (launch + capture).
    localparam int BURST_LEN = 2;
    // Synchroniser depth used for scan enable entering the fast domain.
    localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/occ_sync.sv
// Module: multi-flop synchroniser with synchronous active-low reset.
// Assumes: d_i is a level that stays stable for several clk_i cycles.
module occ_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] stage_q;

    // Shift the asynchronous level through DEPTH flops, clearing to 0 in reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], d_i};
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/occ_clk_gate.sv
// Module: latch-based clock gate; the enable is captured while clk_i is low,
// so the gated clock only ever carries whole high phases of clk_i.
// Assumes: en_i settles within the low phase it is meant for.
module occ_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic open_o,
    output logic gclk_o
);
    logic en_l;

    // Transparent-low latch holding the enable across each high phase.
    always_latch begin
        if (!clk_i) begin
            en_l <= en_i;
        end
    end

    assign open_o = en_l;
    assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/occ_burst_gen.sv
// Module: fast-domain burst generator. It synchronises scan enable, detects
// its falling edge in test mode and loads a shift register. The register's
// low bit enables BURST_LEN consecutive fast cycles.
// Assumes: STAGES >= BURST_LEN + 1, so a zero follows the burst.
module occ_burst_gen
    import occ_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic fast_clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_en,
    output logic se_sync_o,
    output logic burst_en_o
);
    localparam logic [STAGES-1:0] LOAD_PAT =
        {{(STAGES-BURST_LEN){1'b0}}, {BURST_LEN{1'b1}}};

    logic se_sync;
    logic se_prev;
    logic arm;
    logic [STAGES-1:0] shreg_q;

    occ_sync #(.DEPTH(SYNC_DEPTH)) i_se_sync (
        .clk_i (fast_clk),
        .rst_n (rst_n),
        .d_i   (scan_en),
        .q_o   (se_sync)
    );

    // Delay the synchronised scan enable by one cycle for edge detection.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            se_prev <= 1'b0;
        end else begin
            se_prev <= se_sync;
        end
    end

    assign arm = test_mode & se_prev & ~se_sync;

    // Load the pulse pattern on a capture fall, otherwise shift it out.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (arm) begin
            shreg_q <= LOAD_PAT;
        end else begin
            shreg_q <= {1'b0, shreg_q[STAGES-1:1]};
        end
    end

    assign se_sync_o  = se_sync;
    assign burst_en_o = shreg_q[0];
endmodule

// File: rtl/occ_clock_ctrl.sv
// Module: at-speed test clock controller (top). Shift follows the slow clock,
// capture releases a two-pulse fast burst, and functional mode passes the
// fast clock. Both sources go through latch gates and are ORed.
// Assumes: test_mode changes only in reset; scan_en changes while slow_clk low.
module occ_clock_ctrl #(
    parameter int BURST_STAGES = 4
) (
    input  logic fast_clk,
    input  logic slow_clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_en,
    output logic test_clk_o
);
    logic se_sync;
    logic burst_en;
    logic slow_en;
    logic fast_en;
    logic slow_open;
    logic fast_open;
    logic slow_gclk;
    logic fast_gclk;

    occ_burst_gen #(.STAGES(BURST_STAGES)) i_burst (
        .fast_clk   (fast_clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .scan_en    (scan_en),
        .se_sync_o  (se_sync),
        .burst_en_o (burst_en)
    );

    // Gate enables: slow path only in test shift, fast path in functional or burst.
    assign slow_en = test_mode & scan_en;
    assign fast_en = ~test_mode | burst_en;

    occ_clk_gate i_slow_gate (
        .clk_i  (slow_clk),
        .en_i   (slow_en),
        .open_o (slow_open),
        .gclk_o (slow_gclk)
    );

    occ_clk_gate i_fast_gate (
        .clk_i  (fast_clk),
        .en_i   (fast_en),
        .open_o (fast_open),
        .gclk_o (fast_gclk)
    );

    assign test_clk_o = slow_gclk | fast_gclk;
endmodule

// File: rtl/occ_clock_ctrl_chk.sv
// Checker: temporal properties of the test clock controller, bound to the top.
module occ_clock_ctrl_chk (
    input logic fast_clk,
    input logic slow_clk,
    input logic rst_n,
    input logic test_mode,
    input logic scan_en,
    input logic se_sync,
    input logic burst_en,
    input logic slow_open,
    input logic fast_open
);
    // R5
    burst_arm_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (test_mode && $fell(se_sync)) |=> burst_en);

    // R4
    burst_len_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (test_mode && $rose(burst_en)) |=> (burst_en ##1 !burst_en));

    // R1
    func_pass_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        !test_mode |-> fast_open);

    // R7
    gate_mutex_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
        test_mode |-> $onehot0({slow_open, fast_open}));

    // R2
    shift_open_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (test_mode && scan_en && $past(scan_en)) |-> slow_open);

    // R3
    capture_block_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (test_mode && !scan_en && !$past(scan_en)) |-> !slow_open);
endmodule

bind occ_clock_ctrl occ_clock_ctrl_chk i_chk (
    .fast_clk  (fast_clk),
    .slow_clk  (slow_clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_en   (scan_en),
    .se_sync   (se_sync),
    .burst_en  (burst_en),
    .slow_open (slow_open),
    .fast_open (fast_open)
);

// File: tb/test_occ_clock_ctrl.sv
`timescale 1ns/1ps
module test_occ_clock_ctrl;
    localparam real SLOW_H = 10.0;    // 50 MHz tester clock
    localparam real FAST_H = 4.167;   // ~120 MHz PLL clock
    localparam real FAST_T = 2.0 * FAST_H;
    localparam real TOL    = 0.01;

    logic fast_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic scan_en = 1'b0;
    logic test_clk_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int  rise_cnt = 0;
    real first_rise = 0.0;
    real last_rise = -1.0;
    real last_fall = -1.0;
    real min_high = 1.0e9;
    real min_low = 1.0e9;

    occ_clock_ctrl i_occ_clock_ctrl (
        .fast_clk   (fast_clk),
        .slow_clk   (slow_clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .scan_en    (scan_en),
        .test_clk_o (test_clk_o)
    );

    always #(FAST_H) fast_clk = ~fast_clk;
    always #(SLOW_H) slow_clk = ~slow_clk;

    // Edge monitor: counts rises, records widths of every phase.
    always @(posedge test_clk_o) begin
        rise_cnt++;
        if (rise_cnt == 1) first_rise = $realtime;
        if (last_fall >= 0.0 && ($realtime - last_fall) < min_low)
            min_low = $realtime - last_fall;
        last_rise = $realtime;
    end

    always @(negedge test_clk_o) begin
        if (last_rise >= 0.0 && ($realtime - last_rise) < min_high)
            min_high = $realtime - last_rise;
        last_fall = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic win_reset();
        rise_cnt = 0;
        min_high = 1.0e9;
        min_low = 1.0e9;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        real t0;
        real off;
        repeat (5) @(negedge fast_clk);
        rst_n = 1'b1;

        // R1: functional pass-through, scan_en toggled and ignored.
        @(negedge fast_clk);
        win_reset();
        for (int i = 0; i < 40; i++) begin
            @(negedge fast_clk);
            if (i % 7 == 3) scan_en = ~scan_en;
        end
        chk(rise_cnt == 40, "R1", "fast pulses passed", rise_cnt, 40);
        chk(min_high > FAST_H - TOL && min_low > FAST_H - TOL, "R1",
            "pulse width", min_high, FAST_H);

        // R8: enter test mode under reset with scan_en low, then release.
        @(negedge fast_clk);
        rst_n = 1'b0;
        test_mode = 1'b1;
        scan_en = 1'b0;
        win_reset();
        repeat (10) @(negedge fast_clk);
        chk(rise_cnt == 0, "R8", "edges during reset", rise_cnt, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge fast_clk);
        chk(rise_cnt == 0, "R8", "edges after release", rise_cnt, 0);

        // R2: shift follows the slow clock.
        @(negedge slow_clk);
        #2.0;
        scan_en = 1'b1;
        win_reset();
        repeat (12) @(negedge slow_clk);
        chk(rise_cnt == 12, "R2", "slow pulses passed", rise_cnt, 12);
        chk(min_high > SLOW_H - TOL, "R2", "slow high width", min_high, SLOW_H);

        // R3..R7: capture sweep over fall offsets inside the slow low phase.
        for (int k = 0; k < 10; k++) begin
            off = 0.37 + 0.93 * k;
            @(negedge slow_clk);
            #(off);
            t0 = $realtime;
            scan_en = 1'b0;
            win_reset();
            repeat (15) @(negedge slow_clk);
            chk(rise_cnt == 2, "R4", "burst edges", rise_cnt, 2);
            chk(last_rise - first_rise > FAST_T - TOL && last_rise - first_rise < FAST_T + TOL,
                "R4", "burst spacing", last_rise - first_rise, FAST_T);
            chk(first_rise - t0 > 3.0 * FAST_T, "R3", "no slow pulse before burst",
                first_rise - t0, 4.0 * FAST_T);
            chk(first_rise - t0 <= 4.0 * FAST_T + TOL, "R5", "launch latency",
                first_rise - t0, 4.0 * FAST_T);
            chk(min_high > FAST_H - TOL && min_low > FAST_H - TOL, "R7",
                "no runt in capture", min_high, FAST_H);
            if (k == 0) begin
                repeat (50) @(negedge slow_clk);
                chk(rise_cnt == 2, "R6", "quiet after burst", rise_cnt, 2);
            end
            // Return to shift; the first slow pulse must be whole.
            @(negedge slow_clk);
            #(off);
            scan_en = 1'b1;
            win_reset();
            repeat (4) @(negedge slow_clk);
            chk(rise_cnt == 4, "R2", "shift resumes", rise_cnt, 4);
            chk(min_high > SLOW_H - TOL && min_low > FAST_H - TOL, "R7",
                "no runt at return", min_high, SLOW_H);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule